// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block gathers a configurable number of external interrupt lines (64 by default, at most 240) and hands one of them at a time to a processor. Each line carries three state bits, enabled, pending and in service, packed 32 lines to a word, and a four-bit priority level. A rising or held request on an input line marks that line pending. The controller selects the most urgent line that is pending, enabled and not already in service. It shows that line's number and priority together with a request flag.

The processor takes an interrupt by pulsing the acknowledge input, which moves the selected line from pending to in service on the next clock edge. It finishes by pulsing end-of-service with the line number. Software manages the state through a word-addressed register bus. Enable and pending each have a set window and a clear window, where only the written one-bits act. A trigger register lets software make any implemented line pending. Unprivileged bus masters may use it only when a control bit allows it.

All bus reads are combinational from the current state. All writes take effect at the clock edge that ends the write cycle.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset every enable, pending and in-service bit, every priority level and the unprivileged-trigger permission are zero, and `irq_req` is low.
- R2: Line n's enable bit sits in word w = n/32, bit n%32. Writing to word address 0x00+w sets the enable bits where the data has ones, and writing to 0x08+w clears them. Zero data bits change nothing, and a read of either address returns the current enable word.
- R3: Writing to 0x10+w sets pending bits where the data has ones, and writing to 0x18+w clears them. Zero bits change nothing, setting an already pending line leaves it pending, and a read of either address returns the pending word.
- R4: Line n's priority occupies byte n%4 of the word at address 0x40+n/4. Only the upper nibble of that byte is stored, and the lower nibble always reads as zero.
- R5: A pending-clear write has no effect on a line that is in service.
- R6: Only lines that are pending, enabled and not in service compete. The lower priority value wins, and on a tie the lower line number wins. `irq_req` is low when no line competes.
- R7: An `irq_ack` pulse while `irq_req` is high clears the selected line's pending bit and sets its in-service bit at the same edge. The in-service word w reads at 0x20+w. No in-service bit is set any other way.
- R8: A high `irq_in` bit marks its line pending at the next edge. This also holds while the line is in service, so a request can be held again for later service.
- R9: An `eoi_valid` pulse clears the in-service bit of line `eoi_id`.
- R10: A write to 0x80 makes line `wdata[7:0]` pending when that number is below the line count. Larger numbers are ignored.
- R11: A trigger write with `bus_priv` low is ignored unless bit 0 of the control word at 0x81 is one. The control word can be written only with `bus_priv` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Access made at privileged level |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| irq_in | input | NUM_LINES | Interrupt request lines |
| irq_req | output | 1 | A line is waiting for the processor |
| irq_id | output | 8 | Number of the selected line |
| irq_prio | output | 4 | Priority of the selected line |
| irq_ack | input | 1 | Processor takes the selected line |
| eoi_valid | input | 1 | End-of-service strobe |
| eoi_id | input | 8 | Line whose service ends |

## Verification
The assertions check four properties on every cycle. The presented line must really be pending, enabled and idle. Acknowledge must move exactly that line into service, and end-of-service must clear its line. A line in service must never lose its pending bit, and no in-service bit may appear without an acknowledge. Priority reads must also show empty low nibbles. The bench scenarios cover the rest. These include which competitor wins on priority and on ties, and that zero bits in set and clear writes leave state alone. They also cover that out-of-range and unprivileged trigger writes change nothing, and that a request held during service comes back after end-of-service.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int WORD_W    = 32;
    localparam int MAX_LINES = 240;
    localparam int PRIO_W    = 4;
    localparam int ADDR_W    = 8;
    localparam int ID_W      = 8;

    // word-address windows
    localparam int A_EN_SET = 'h00;
    localparam int A_EN_CLR = 'h08;
    localparam int A_PD_SET = 'h10;
    localparam int A_PD_CLR = 'h18;
    localparam int A_ACTIVE = 'h20;
    localparam int A_PRIO   = 'h40;
    localparam int A_TRIG   = 'h80;
    localparam int A_TCTL   = 'h81;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_EN_SET,
        RG_EN_CLR,
        RG_PD_SET,
        RG_PD_CLR,
        RG_ACTIVE,
        RG_PRIO,
        RG_TRIG,
        RG_TCTL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [6:0] index;
    } reg_hit_t;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } pick_t;

    function automatic reg_hit_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int nwords,
                                             input int nprio);
        reg_hit_t h;
        int       ai;
        ai      = int'(a);
        h.kind  = RG_NONE;
        h.index = '0;
        if (ai >= A_EN_SET && ai < A_EN_SET + nwords) begin
            h.kind  = RG_EN_SET;
            h.index = 7'(ai - A_EN_SET);
        end else if (ai >= A_EN_CLR && ai < A_EN_CLR + nwords) begin
            h.kind  = RG_EN_CLR;
            h.index = 7'(ai - A_EN_CLR);
        end else if (ai >= A_PD_SET && ai < A_PD_SET + nwords) begin
            h.kind  = RG_PD_SET;
            h.index = 7'(ai - A_PD_SET);
        end else if (ai >= A_PD_CLR && ai < A_PD_CLR + nwords) begin
            h.kind  = RG_PD_CLR;
            h.index = 7'(ai - A_PD_CLR);
        end else if (ai >= A_ACTIVE && ai < A_ACTIVE + nwords) begin
            h.kind  = RG_ACTIVE;
            h.index = 7'(ai - A_ACTIVE);
        end else if (ai >= A_PRIO && ai < A_PRIO + nprio) begin
            h.kind  = RG_PRIO;
            h.index = 7'(ai - A_PRIO);
        end else if (ai == A_TRIG) begin
            h.kind = RG_TRIG;
        end else if (ai == A_TCTL) begin
            h.kind = RG_TCTL;
        end
        return h;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                                  bus_sel,
    input  logic                                  bus_we,
    input  logic                                  bus_priv,
    input  logic [ADDR_W-1:0]                     bus_addr,
    input  logic [WORD_W-1:0]                     bus_wdata,
    input  logic                                  allow_unpriv,
    output reg_hit_t                              hit,
    output logic [NUM_LINES-1:0]                  en_set_m,
    output logic [NUM_LINES-1:0]                  en_clr_m,
    output logic [NUM_LINES-1:0]                  pd_set_m,
    output logic [NUM_LINES-1:0]                  pd_clr_m,
    output logic [NUM_LINES-1:0]                  trig_m,
    output logic [NUM_LINES-1:0]                  prio_we,
    output logic [3:0][PRIO_W-1:0]                prio_val,
    output logic                                  tctl_we,
    output logic                                  tctl_d
);

    localparam int NW  = (NUM_LINES + WORD_W - 1) / WORD_W;
    localparam int NP  = NW * WORD_W;
    localparam int NPW = (NUM_LINES + 3) / 4;

    logic          wr;
    logic          trig_ok;
    logic [NP-1:0] word_m;

    assign hit     = decode_addr(bus_addr, NW, NPW);
    assign wr      = bus_sel && bus_we;
    assign trig_ok = wr && (hit.kind == RG_TRIG) && (bus_priv || allow_unpriv);
    assign tctl_we = wr && (hit.kind == RG_TCTL) && bus_priv;
    assign tctl_d  = bus_wdata[0];

    // place the write data at the addressed word of a line-wide mask
    always_comb begin
        word_m = '0;
        for (int w = 0; w < NW; w++) begin
            if (int'(hit.index) == w) begin
                word_m[w*WORD_W +: WORD_W] = bus_wdata;
            end
        end
    end

    assign en_set_m = (wr && hit.kind == RG_EN_SET) ? word_m[NUM_LINES-1:0] : '0;
    assign en_clr_m = (wr && hit.kind == RG_EN_CLR) ? word_m[NUM_LINES-1:0] : '0;
    assign pd_set_m = (wr && hit.kind == RG_PD_SET) ? word_m[NUM_LINES-1:0] : '0;
    assign pd_clr_m = (wr && hit.kind == RG_PD_CLR) ? word_m[NUM_LINES-1:0] : '0;

    genvar lane;
    generate
        for (lane = 0; lane < 4; lane++) begin : g_lane
            assign prio_val[lane] = bus_wdata[lane*8 + 8 - PRIO_W +: PRIO_W];
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            prio_we[i] = wr && (hit.kind == RG_PRIO) && (int'(hit.index) == i / 4);
            trig_m[i]  = trig_ok && (int'(bus_wdata[7:0]) == i);
        end
    end

endmodule

// File: rtl/irq_line_state.sv
module irq_line_state
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] en_set_m,
    input  logic [NUM_LINES-1:0] en_clr_m,
    input  logic [NUM_LINES-1:0] pd_set_m,
    input  logic [NUM_LINES-1:0] pd_clr_m,
    input  logic [NUM_LINES-1:0] trig_m,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] ack_m,
    input  logic [NUM_LINES-1:0] eoi_m,
    output logic [NUM_LINES-1:0] enable_q,
    output logic [NUM_LINES-1:0] pending_q,
    output logic [NUM_LINES-1:0] active_q
);

    genvar n;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_line
            logic raise;
            logic drop;
            assign raise = pd_set_m[n] | trig_m[n] | irq_in[n];
            // a clear request cannot touch a line in service
            assign drop  = ack_m[n] | (pd_clr_m[n] & ~active_q[n]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    enable_q[n]  <= 1'b0;
                    pending_q[n] <= 1'b0;
                    active_q[n]  <= 1'b0;
                end else begin
                    if (en_set_m[n]) begin
                        enable_q[n] <= 1'b1;
                    end else if (en_clr_m[n]) begin
                        enable_q[n] <= 1'b0;
                    end
                    if (drop) begin
                        pending_q[n] <= 1'b0;
                    end else if (raise) begin
                        pending_q[n] <= 1'b1;
                    end
                    if (ack_m[n]) begin
                        active_q[n] <= 1'b1;
                    end else if (eoi_m[n]) begin
                        active_q[n] <= 1'b0;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_LINES-1:0]              prio_we,
    input  logic [3:0][PRIO_W-1:0]            prio_val,
    input  logic [6:0]                        rd_idx,
    output logic [NUM_LINES-1:0][PRIO_W-1:0]  prio_q,
    output logic [WORD_W-1:0]                 rd_word
);

    genvar n;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_prio
            always_ff @(posedge clk) begin
                if (rst) begin
                    prio_q[n] <= '0;
                end else if (prio_we[n]) begin
                    prio_q[n] <= prio_val[n % 4];
                end
            end
        end
    endgenerate

    // low nibble of every byte stays zero on read
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (int'(rd_idx) == i / 4) begin
                rd_word[(i % 4)*8 + 8 - PRIO_W +: PRIO_W] = prio_q[i];
            end
        end
    end

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic [NUM_LINES-1:0]             cand,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    output pick_t                            pick
);

    // ascending scan with strict compare keeps the lowest number on ties
    always_comb begin
        pick       = '0;
        pick.prio  = '1;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (cand[i] && (!pick.valid || prio[i] < pick.prio)) begin
                pick.valid = 1'b1;
                pick.id    = ID_W'(i);
                pick.prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic                 bus_priv,
    input  logic [7:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 irq_req,
    output logic [7:0]           irq_id,
    output logic [3:0]           irq_prio,
    input  logic                 irq_ack,
    input  logic                 eoi_valid,
    input  logic [7:0]           eoi_id
);

    localparam int NW = (NUM_LINES + WORD_W - 1) / WORD_W;
    localparam int NP = NW * WORD_W;

    initial begin
        if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin
            $error("NUM_LINES out of range");
        end
    end

    reg_hit_t                             hit;
    logic [NUM_LINES-1:0]                 en_set_m, en_clr_m, pd_set_m, pd_clr_m, trig_m;
    logic [NUM_LINES-1:0]                 prio_we;
    logic [3:0][PRIO_W-1:0]               prio_val;
    logic                                 tctl_we, tctl_d, allow_unpriv_q;
    logic [NUM_LINES-1:0]                 enable_q, pending_q, active_q;
    logic [NUM_LINES-1:0]                 ack_m, eoi_m, cand;
    logic [NUM_LINES-1:0][PRIO_W-1:0]     prio_q;
    logic [WORD_W-1:0]                    prio_word;
    logic [NP-1:0]                        en_pad, pd_pad, act_pad;
    logic [WORD_W-1:0]                    en_word, pd_word, act_word;
    pick_t                                pick;

    irq_reg_decode #(.NUM_LINES(NUM_LINES)) u_decode (
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_priv     (bus_priv),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .allow_unpriv (allow_unpriv_q),
        .hit          (hit),
        .en_set_m     (en_set_m),
        .en_clr_m     (en_clr_m),
        .pd_set_m     (pd_set_m),
        .pd_clr_m     (pd_clr_m),
        .trig_m       (trig_m),
        .prio_we      (prio_we),
        .prio_val     (prio_val),
        .tctl_we      (tctl_we),
        .tctl_d       (tctl_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            allow_unpriv_q <= 1'b0;
        end else if (tctl_we) begin
            allow_unpriv_q <= tctl_d;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            ack_m[i] = irq_ack && pick.valid && (pick.id == ID_W'(i));
            eoi_m[i] = eoi_valid && (eoi_id == ID_W'(i));
        end
    end

    irq_line_state #(.NUM_LINES(NUM_LINES)) u_state (
        .clk       (clk),
        .rst       (rst),
        .en_set_m  (en_set_m),
        .en_clr_m  (en_clr_m),
        .pd_set_m  (pd_set_m),
        .pd_clr_m  (pd_clr_m),
        .trig_m    (trig_m),
        .irq_in    (irq_in),
        .ack_m     (ack_m),
        .eoi_m     (eoi_m),
        .enable_q  (enable_q),
        .pending_q (pending_q),
        .active_q  (active_q)
    );

    irq_prio_store #(.NUM_LINES(NUM_LINES)) u_prio (
        .clk      (clk),
        .rst      (rst),
        .prio_we  (prio_we),
        .prio_val (prio_val),
        .rd_idx   (hit.index),
        .prio_q   (prio_q),
        .rd_word  (prio_word)
    );

    assign cand = pending_q & enable_q & ~active_q;

    irq_select #(.NUM_LINES(NUM_LINES)) u_select (
        .cand (cand),
        .prio (prio_q),
        .pick (pick)
    );

    assign irq_req  = pick.valid;
    assign irq_id   = pick.id;
    assign irq_prio = pick.prio;

    // read path
    always_comb begin
        en_pad  = '0;
        pd_pad  = '0;
        act_pad = '0;
        en_pad[NUM_LINES-1:0]  = enable_q;
        pd_pad[NUM_LINES-1:0]  = pending_q;
        act_pad[NUM_LINES-1:0] = active_q;
        en_word  = '0;
        pd_word  = '0;
        act_word = '0;
        for (int w = 0; w < NW; w++) begin
            if (int'(hit.index) == w) begin
                en_word  = en_pad[w*WORD_W +: WORD_W];
                pd_word  = pd_pad[w*WORD_W +: WORD_W];
                act_word = act_pad[w*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            unique case (hit.kind)
                RG_EN_SET, RG_EN_CLR: bus_rdata = en_word;
                RG_PD_SET, RG_PD_CLR: bus_rdata = pd_word;
                RG_ACTIVE:            bus_rdata = act_word;
                RG_PRIO:              bus_rdata = prio_word;
                RG_TCTL:              bus_rdata = {31'b0, allow_unpriv_q};
                default:              bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] enable_q,
    input logic [NUM_LINES-1:0] pending_q,
    input logic [NUM_LINES-1:0] active_q,
    input logic                 irq_req,
    input logic [7:0]           irq_id,
    input logic                 irq_ack,
    input logic                 eoi_valid,
    input logic [7:0]           eoi_id,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [7:0]           bus_addr,
    input logic [31:0]          bus_rdata
);

    localparam int NPW = (NUM_LINES + 3) / 4;

    logic [NUM_LINES-1:0] id_oh, eoi_oh;
    logic                 rd_prio;
    logic                 taken;

    assign id_oh   = NUM_LINES'(1) << irq_id;
    assign eoi_oh  = NUM_LINES'(1) << eoi_id;
    assign rd_prio = bus_sel && !bus_we &&
                     int'(bus_addr) >= A_PRIO && int'(bus_addr) < A_PRIO + NPW;
    assign taken   = irq_req && irq_ack;

    // R6: presented line is a real competitor
    a_r6_pick_eligible: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (int'(irq_id) < NUM_LINES) &&
                    ((pending_q & enable_q & ~active_q & id_oh) != '0));

    // R7: acknowledge moves the presented line into service
    a_r7_ack_moves: assert property (@(posedge clk) disable iff (rst)
        taken |=> ((active_q & $past(id_oh)) != '0) &&
                  ((pending_q & $past(id_oh)) == '0));

    // R7: no in-service bit appears without an acknowledge
    a_r7_active_source: assert property (@(posedge clk) disable iff (rst)
        ((active_q & ~$past(active_q)) != '0) |-> $past(taken));

    // R9: end-of-service clears its line
    a_r9_eoi_clears: assert property (@(posedge clk) disable iff (rst)
        (eoi_valid && !(taken && irq_id == eoi_id)) |=>
            ((active_q & $past(eoi_oh)) == '0));

    // R5: a line in service never loses its pending bit
    a_r5_pending_held: assert property (@(posedge clk) disable iff (rst)
        (($past(pending_q) & $past(active_q) & ~pending_q) == '0));

    // R4: priority reads carry empty low nibbles
    a_r4_low_nibble: assert property (@(posedge clk) disable iff (rst)
        rd_prio |-> ((bus_rdata & 32'h0F0F_0F0F) == '0));

endmodule

bind irq_ctrl_core irq_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable_q  (enable_q),
    .pending_q (pending_q),
    .active_q  (active_q),
    .irq_req   (irq_req),
    .irq_id    (irq_id),
    .irq_ack   (irq_ack),
    .eoi_valid (eoi_valid),
    .eoi_id    (eoi_id),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/irq_ctrl_core_bench.sv
`timescale 1ns/100ps
module irq_ctrl_core_bench;

    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_sel = 1'b0, bus_we = 1'b0, bus_priv = 1'b1;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] irq_in = '0;
    logic         irq_req;
    logic [7:0]   irq_id;
    logic [3:0]   irq_prio;
    logic         irq_ack = 1'b0;
    logic         eoi_valid = 1'b0;
    logic [7:0]   eoi_id = '0;

    always #2 clk = ~clk;

    irq_ctrl_core #(.NUM_LINES(N)) u_irq_ctrl_core (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_priv  (bus_priv),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .irq_req   (irq_req),
        .irq_id    (irq_id),
        .irq_prio  (irq_prio),
        .irq_ack   (irq_ack),
        .eoi_valid (eoi_valid),
        .eoi_id    (eoi_id)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        mon_rd = 1'b0;

    // monitor: compare each read against the queued expectation
    always @(negedge clk) begin
        if (mon_rd && exp_q.size() > 0) begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic p);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_priv = p; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        mon_rd = 1'b1;
        @(negedge clk); #1;
        mon_rd = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic chk_irq(input logic req, input logic [7:0] id, input string t);
        @(negedge clk);
        checks++;
        if (irq_req !== req || (req && irq_id !== id)) begin
            errors++;
            $display("FAIL %s: req=%b id=%0d expected req=%b id=%0d", t, irq_req, irq_id, req, id);
        end
    endtask

    task automatic take_irq();
        @(posedge clk); #1; irq_ack = 1'b1;
        @(posedge clk); #1; irq_ack = 1'b0;
    endtask

    task automatic end_irq(input logic [7:0] id);
        @(posedge clk); #1; eoi_valid = 1'b1; eoi_id = id;
        @(posedge clk); #1; eoi_valid = 1'b0;
    endtask

    task automatic pulse_line(input int n);
        @(posedge clk); #1; irq_in[n] = 1'b1;
        @(posedge clk); #1; irq_in[n] = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        bus_rd(8'h00, 32'h0, "R1 enable word0");
        bus_rd(8'h11, 32'h0, "R1 pending word1");
        bus_rd(8'h40, 32'h0, "R1 priority word0");
        bus_rd(8'h81, 32'h0, "R1 trigger control");
        chk_irq(1'b0, 8'd0, "R1 no request");

        // R2 enable set/clear
        bus_wr(8'h00, 32'h0000_0408, 1'b1);
        bus_wr(8'h01, 32'h0000_0100, 1'b1);
        bus_rd(8'h00, 32'h0000_0408, "R2 enable set word0");
        bus_rd(8'h09, 32'h0000_0100, "R2 enable via clear window word1");
        bus_wr(8'h00, 32'h0, 1'b1);
        bus_rd(8'h00, 32'h0000_0408, "R2 zero set bits no effect");
        bus_wr(8'h08, 32'h0000_0400, 1'b1);
        bus_rd(8'h00, 32'h0000_0008, "R2 clear line 10");
        bus_wr(8'h00, 32'h0000_0400, 1'b1);

        // R4 priority
        bus_wr(8'h40, 32'hFFFF_FFFF, 1'b1);
        bus_rd(8'h40, 32'hF0F0_F0F0, "R4 low nibbles read zero");
        bus_wr(8'h40, 32'h5A00_0000, 1'b1);
        bus_rd(8'h40, 32'h5000_0000, "R4 line 3 byte");
        bus_wr(8'h42, 32'h0050_0000, 1'b1);
        bus_wr(8'h4A, 32'h0000_0030, 1'b1);
        bus_rd(8'h4A, 32'h0000_0030, "R4 line 40 byte");

        // R3 pending set/clear, disabled line does not compete (R6)
        bus_wr(8'h10, 32'h0000_0020, 1'b1);
        bus_rd(8'h10, 32'h0000_0020, "R3 pending set line 5");
        chk_irq(1'b0, 8'd0, "R6 disabled pending line ignored");
        bus_wr(8'h10, 32'h0000_0020, 1'b1);
        bus_rd(8'h18, 32'h0000_0020, "R3 set again no change");
        bus_wr(8'h18, 32'h0000_0020, 1'b1);
        bus_rd(8'h10, 32'h0, "R3 pending clear");

        // R6 arbitration
        bus_wr(8'h10, 32'h0000_0408, 1'b1);
        chk_irq(1'b1, 8'd3, "R6 tie goes to lower number");
        bus_wr(8'h11, 32'h0000_0100, 1'b1);
        chk_irq(1'b1, 8'd40, "R6 lower value wins");

        // R7 acknowledge, R8 re-pend, R5 clear blocked, R9 end
        take_irq();
        bus_rd(8'h21, 32'h0000_0100, "R7 line 40 in service");
        bus_rd(8'h11, 32'h0, "R7 line 40 pending cleared");
        chk_irq(1'b1, 8'd3, "R7 next line presented");
        pulse_line(40);
        bus_rd(8'h11, 32'h0000_0100, "R8 request during service pends");
        chk_irq(1'b1, 8'd3, "R6 in-service line excluded");
        bus_wr(8'h19, 32'h0000_0100, 1'b1);
        bus_rd(8'h11, 32'h0000_0100, "R5 clear ignored while in service");
        end_irq(8'd40);
        bus_rd(8'h21, 32'h0, "R9 end of service");
        chk_irq(1'b1, 8'd40, "R8 held request returns");
        take_irq();
        end_irq(8'd40);
        bus_rd(8'h11, 32'h0, "R7 line 40 pending after second take");
        take_irq();
        chk_irq(1'b1, 8'd10, "R7 line 10 after line 3");
        take_irq();
        chk_irq(1'b0, 8'd0, "R6 none left");
        bus_rd(8'h20, 32'h0000_0408, "R7 lines 3 and 10 in service");
        end_irq(8'd3);
        end_irq(8'd10);
        bus_rd(8'h20, 32'h0, "R9 both ended");
        pulse_line(5);
        bus_rd(8'h10, 32'h0000_0020, "R8 input latched pending");

        // R10, R11 software trigger
        bus_wr(8'h80, 32'd20, 1'b1);
        bus_rd(8'h10, 32'h0010_0020, "R10 privileged trigger");
        bus_wr(8'h80, 32'd21, 1'b0);
        bus_rd(8'h10, 32'h0010_0020, "R11 unprivileged trigger ignored");
        bus_wr(8'h81, 32'h1, 1'b0);
        bus_rd(8'h81, 32'h0, "R11 unprivileged control write ignored");
        bus_wr(8'h81, 32'h1, 1'b1);
        bus_rd(8'h81, 32'h1, "R11 privileged control write");
        bus_wr(8'h80, 32'd22, 1'b0);
        bus_rd(8'h10, 32'h0050_0020, "R11 unprivileged trigger permitted");
        bus_wr(8'h80, 32'd100, 1'b1);
        bus_rd(8'h10, 32'h0050_0020, "R10 out-of-range word0 unchanged");
        bus_rd(8'h11, 32'h0, "R10 out-of-range word1 unchanged");
        bus_wr(8'h80, 32'd63, 1'b1);
        bus_rd(8'h11, 32'h8000_0000, "R10 top line trigger");

        repeat (2) @(posedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule